// File: doc/BRIEF.md
# Sign-Error LMS Adaptive Bit Demodulator

This block turns a stream of signed baseband samples into hard data bits. The samples come from a noisy serial link and already arrive one per symbol. A single adaptive gain coefficient scales each accepted sample. The scaled value is sliced into a bit. The coefficient is then corrected by a small step whose direction depends only on the sign of the slicing error. Bits are smoothed by a majority vote over the most recent sixteen decisions, which removes isolated errors caused by interference bursts.

The datapath is built for hardware cost. The coefficient correction uses only negation, an arithmetic right shift and a saturating add, with no multiplier in that path. All intermediate widths are fixed and bounded. A stream controller feeds samples with a valid strobe. The block returns one smoothed bit with its own valid strobe per accepted sample once the vote window is full.

Top module: `sign_lms_demod`

## Requirements
- R1: While reset is high and in the cycle after it falls, out_valid is 0 and out_bit is 0. Reset also sets the gain to 1.0 (16384 with 14 fractional bits) and empties the vote window.
- R2: For an accepted sample x, the scaled value is y = floor(gain·x / 2^14), clamped to the range −2048..2047.
- R3: The raw decision is 1 when y ≥ 0 and 0 when y < 0, so y = 0 decides 1.
- R4: The slicing error is e = r − y, where r = +2047 for a decision of 1 and r = −2047 for a decision of 0.
- R5: For each accepted sample the gain changes by floor(s·|x| / 64), where s is +1, −1 or 0 as e is positive, negative or zero. The gain does not change in cycles with in_valid low.
- R6: The gain saturates at +32767 and −32768 and never wraps.
- R7: Each output bit is the majority of the last 16 raw decisions, the newest included: 1 if more than 8 are ones, 0 if fewer than 8 are ones.
- R8: When exactly 8 of the 16 decisions are ones, the output repeats the previous output bit. That previous bit is 0 if no bit has been output since reset.
- R9: out_valid is high for exactly one cycle, in the cycle after each accepted sample, starting with the 16th accepted sample after reset. Before that, out_valid stays low.
- R10: out_bit changes only in cycles in which out_valid is high. Cycles with in_valid low produce no output and leave the window unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 12 | Signed two's complement sample |
| out_valid | output | 1 | Smoothed bit strobe |
| out_bit | output | 1 | Smoothed demodulated bit |

## Verification
A wrong gain value is hidden at first, because the majority vote and the slicer both tolerate small gain errors. It shows at the ports only once the gain sign flips or the gain saturates, after hundreds or tens of thousands of samples. For that reason the bench drives long one-sided runs that push the gain across zero and into its upper limit, and then checks the decisions on opposite-sign samples. A wrong window or fill count shows within 16 samples, as an early, missing or extra strobe or a wrong tie outcome.

// File: rtl/sign_lms_demod_pkg.sv
package sign_lms_demod_pkg;
    // default geometry of the demodulator
    localparam int SAMPLE_W_DEF = 12;
    localparam int GAIN_W_DEF   = 16;
    localparam int GAIN_FRAC_DEF = 14;
    localparam int STEP_SHIFT_DEF = 6;
    localparam int VOTE_LEN_DEF = 16;

    // polarity of the raw slicer decision
    typedef enum logic {
        SLICE_NEG = 1'b0,
        SLICE_POS = 1'b1
    } slice_e;
endpackage

// File: rtl/slms_tap.sv
module slms_tap
    import sign_lms_demod_pkg::*;
#(
    parameter int XW = SAMPLE_W_DEF,
    parameter int WW = GAIN_W_DEF,
    parameter int WF = GAIN_FRAC_DEF,
    parameter int MU = STEP_SHIFT_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid,
    input  logic signed [XW-1:0] smp,
    output slice_e               decision,
    output logic signed [WW-1:0] gain
);
    localparam int PW = XW + WW;
    localparam int EW = XW + 1;
    localparam logic signed [PW-1:0] Y_HI_P = PW'((2 ** (XW - 1)) - 1);
    localparam logic signed [PW-1:0] Y_LO_P = -PW'(2 ** (XW - 1));
    localparam logic signed [XW-1:0] Y_HI = {1'b0, {(XW - 1){1'b1}}};
    localparam logic signed [XW-1:0] Y_LO = {1'b1, {(XW - 1){1'b0}}};
    localparam logic signed [EW-1:0] REF_P = EW'((2 ** (XW - 1)) - 1);
    localparam logic signed [EW-1:0] REF_N = -EW'((2 ** (XW - 1)) - 1);
    localparam logic signed [WW:0] G_HI = (WW + 1)'((2 ** (WW - 1)) - 1);
    localparam logic signed [WW:0] G_LO = -(WW + 1)'(2 ** (WW - 1));
    localparam logic signed [WW-1:0] G_INIT = WW'(2 ** WF);

    typedef struct packed {
        logic signed [WW-1:0] g;
    } tap_st_t;

    tap_st_t st_d, st_q;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] y_full;
    logic signed [XW-1:0] y;
    logic signed [EW-1:0] err;
    logic signed [EW-1:0] x_ext;
    logic signed [EW-1:0] x_mag;
    logic signed [EW-1:0] step_raw;
    logic signed [EW-1:0] step;
    logic signed [WW:0]   g_sum;
    slice_e               dec;

    always_comb begin
        st_d   = st_q;
        prod   = $signed(st_q.g) * $signed(smp);
        y_full = prod >>> WF;
        if (y_full > Y_HI_P) begin
            y = Y_HI;
        end else if (y_full < Y_LO_P) begin
            y = Y_LO;
        end else begin
            y = y_full[XW-1:0];
        end
        dec   = y[XW-1] ? SLICE_NEG : SLICE_POS;
        err   = ((dec == SLICE_POS) ? REF_P : REF_N) - $signed({y[XW-1], y});
        x_ext = $signed({smp[XW-1], smp});
        x_mag = x_ext[EW-1] ? -x_ext : x_ext;
        if (err > 0) begin
            step_raw = x_mag;
        end else if (err < 0) begin
            step_raw = -x_mag;
        end else begin
            step_raw = '0;
        end
        step  = step_raw >>> MU;
        g_sum = $signed({st_q.g[WW-1], st_q.g}) + $signed({{(WW + 1 - EW){step[EW-1]}}, step});
        if (smp_valid) begin
            if (g_sum > G_HI) begin
                st_d.g = G_HI[WW-1:0];
            end else if (g_sum < G_LO) begin
                st_d.g = G_LO[WW-1:0];
            end else begin
                st_d.g = g_sum[WW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.g <= G_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign decision = dec;
    assign gain     = st_q.g;
endmodule

// File: rtl/slms_vote.sv
module slms_vote
    import sign_lms_demod_pkg::*;
#(
    parameter int WIN = VOTE_LEN_DEF
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   dec_valid,
    input  slice_e dec,
    output logic   vote_valid,
    output logic   vote_bit
);
    localparam int CW = $clog2(WIN + 1);

    typedef struct packed {
        logic [WIN-1:0] win;
        logic [CW-1:0]  fill;
        logic           bit_o;
        logic           vld;
    } vote_st_t;

    vote_st_t st_d, st_q;

    logic [WIN-1:0] win_n;
    logic [CW-1:0]  fill_n;
    logic [CW-1:0]  ones;
    logic [CW:0]    ones2;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        win_n    = {st_q.win[WIN-2:0], (dec == SLICE_POS)};
        fill_n   = (st_q.fill < CW'(WIN)) ? st_q.fill + 1'b1 : st_q.fill;
        ones     = CW'($countones(win_n));
        ones2    = {ones, 1'b0};
        if (dec_valid) begin
            st_d.win  = win_n;
            st_d.fill = fill_n;
            if (fill_n == CW'(WIN)) begin
                st_d.vld = 1'b1;
                if (ones2 > (CW + 1)'(WIN)) begin
                    st_d.bit_o = 1'b1;
                end else if (ones2 < (CW + 1)'(WIN)) begin
                    st_d.bit_o = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vote_valid = st_q.vld;
    assign vote_bit   = st_q.bit_o;
endmodule

// File: rtl/sign_lms_demod.sv
module sign_lms_demod
    import sign_lms_demod_pkg::*;
#(
    parameter int XW  = SAMPLE_W_DEF,
    parameter int WW  = GAIN_W_DEF,
    parameter int WF  = GAIN_FRAC_DEF,
    parameter int MU  = STEP_SHIFT_DEF,
    parameter int WIN = VOTE_LEN_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [XW-1:0] in_sample,
    output logic          out_valid,
    output logic          out_bit
);
    slice_e               raw_dec;
    logic signed [WW-1:0] gain_cur;

    slms_tap #(
        .XW(XW),
        .WW(WW),
        .WF(WF),
        .MU(MU)
    ) u_tap (
        .clk      (clk),
        .rst      (rst),
        .smp_valid(in_valid),
        .smp      ($signed(in_sample)),
        .decision (raw_dec),
        .gain     (gain_cur)
    );

    slms_vote #(
        .WIN(WIN)
    ) u_vote (
        .clk       (clk),
        .rst       (rst),
        .dec_valid (in_valid),
        .dec       (raw_dec),
        .vote_valid(out_valid),
        .vote_bit  (out_bit)
    );
endmodule

// File: rtl/sign_lms_demod_check.sv
module sign_lms_demod_check #(
    parameter int XW  = 12,
    parameter int WW  = 16,
    parameter int WF  = 14,
    parameter int MU  = 6,
    parameter int WIN = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic                 out_bit,
    input logic signed [WW-1:0] gain
);
    localparam int CW = $clog2(WIN + 1);
    localparam logic signed [WW:0] STEP_MAX = (WW + 1)'(2 ** (XW - MU));
    localparam logic signed [WW-1:0] G_INIT = WW'(2 ** WF);

    logic [CW-1:0]        seen_q;
    logic signed [WW-1:0] gain_prev;
    logic signed [WW:0]   gain_diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (in_valid && seen_q < CW'(WIN)) begin
            seen_q <= seen_q + 1'b1;
        end
        gain_prev <= gain;
    end

    assign gain_diff = $signed({gain[WW-1], gain}) - $signed({gain_prev[WW-1], gain_prev});

    // R1: reset restores the unit gain and drops the strobe
    p_reset_state_r1: assert property (@(posedge clk) rst |=> (gain == G_INIT && !out_valid && !out_bit));

    // R9: strobe only follows an accepted sample
    p_strobe_follows_r9: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(in_valid));

    // R9: no strobe and zero bit before the window fills
    p_no_early_r9: assert property (@(posedge clk) disable iff (rst) (seen_q < CW'(WIN)) |-> (!out_valid && !out_bit));

    // R10: idle cycles leave output alone
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(out_bit) && !out_valid));

    // R5: gain is frozen without a sample
    p_gain_frozen_r5: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(gain));

    // R5: one correction never exceeds the shifted sample magnitude
    p_gain_step_r5: assert property (@(posedge clk) disable iff (rst) in_valid |=> (gain_diff <= STEP_MAX && gain_diff >= -STEP_MAX));
endmodule

bind sign_lms_demod sign_lms_demod_check #(
    .XW (XW),
    .WW (WW),
    .WF (WF),
    .MU (MU),
    .WIN(WIN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_bit  (out_bit),
    .gain     (gain_cur)
);

// File: tb/sign_lms_demod_bench.sv
module sign_lms_demod_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_sample = '0;
    logic        out_valid;
    logic        out_bit;

    int checks = 0;
    int errs = 0;
    int out_cnt = 0;
    logic last_bit = 1'b0;

    typedef struct {
        logic  b;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    // reference state computed from the requirements
    int       g_m;
    logic [15:0] win_m;
    int       fill_m;
    logic     prev_m;

    always #4 clk = ~clk;

    sign_lms_demod u_sign_lms_demod (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sample(in_sample),
        .out_valid(out_valid),
        .out_bit  (out_bit)
    );

    task automatic model_reset();
        g_m    = 16384;
        win_m  = '0;
        fill_m = 0;
        prev_m = 1'b0;
        exp_q.delete();
    endtask

    task automatic send(input int x);
        int   y;
        int   r;
        int   e;
        int   ax;
        int   sv;
        int   ones;
        logic b;
        exp_t it;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 12'(x);
        y = (g_m * x) >>> 14;                 // R2
        if (y > 2047) y = 2047;
        if (y < -2048) y = -2048;
        b = (y >= 0);                         // R3
        r = b ? 2047 : -2047;                 // R4
        e = r - y;
        ax = (x < 0) ? -x : x;
        sv = (e > 0) ? ax : ((e < 0) ? -ax : 0);
        g_m = g_m + (sv >>> 6);               // R5
        if (g_m > 32767) g_m = 32767;         // R6
        if (g_m < -32768) g_m = -32768;
        win_m = {win_m[14:0], b};
        if (fill_m < 16) fill_m++;
        if (fill_m == 16) begin
            ones = $countones(win_m);
            if (ones > 8) begin
                it.b = 1'b1; it.tag = "R7";
            end else if (ones < 8) begin
                it.b = 1'b0; it.tag = "R7";
            end else begin
                it.b = prev_m; it.tag = "R8";
            end
            prev_m = it.b;
            exp_q.push_back(it);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sample = 12'($urandom_range(0, 4095));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_bit !== 1'b0) begin
            errs++;
            $display("FAIL R1 reset state: valid=%b bit=%b expected valid=0 bit=0", out_valid, out_bit);
        end
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            if (out_valid) begin
                out_cnt++;
                checks++;
                if (exp_q.size() == 0) begin
                    errs++;
                    $display("FAIL R9 unexpected strobe: actual valid=1 expected valid=0");
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    if (out_bit !== it.b) begin
                        errs++;
                        $display("FAIL %s bit: actual=%b expected=%b", it.tag, out_bit, it.b);
                    end
                end
            end else if (out_bit !== last_bit) begin
                checks++;
                errs++;
                $display("FAIL R10 bit moved without strobe: actual=%b expected=%b", out_bit, last_bit);
            end
        end
        last_bit = out_bit;
    end

    task automatic finish_run();
        idle(4);
        checks++;
        if (exp_q.size() != 0) begin
            errs++;
            $display("FAIL R9 missing strobes: actual pending=%0d expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();                                     // R1

        // R9: fifteen samples give no strobe
        for (int i = 0; i < 15; i++) send(500);
        idle(3);
        checks++;
        if (out_cnt != 0) begin
            errs++;
            $display("FAIL R9 early output: actual=%0d expected=0", out_cnt);
        end

        // R7 then R8: full window, then ties in both directions
        send(500);
        for (int i = 0; i < 12; i++) send(-500);
        for (int i = 0; i < 16; i++) send(500);
        for (int i = 0; i < 8; i++) send(-500);
        idle(2);

        // R2, R4, R5, R10: random samples with gaps
        for (int i = 0; i < 400; i++) begin
            send(int'($urandom_range(0, 4095)) - 2048);
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
        end

        // R5, R3: long negative run pulls the gain through zero
        for (int i = 0; i < 700; i++) send(-2047);
        for (int i = 0; i < 40; i++) send((i % 2) ? 1500 : -1500);

        // R6: small positive run saturates the gain, then negative samples
        do_reset();
        for (int i = 0; i < 16500; i++) send(64);
        for (int i = 0; i < 24; i++) send(-1000);

        // R3: decisions at and just below zero
        do_reset();
        for (int i = 0; i < 20; i++) send(0);
        for (int i = 0; i < 20; i++) send(-1);
        for (int i = 0; i < 20; i++) send(-2048);
        for (int i = 0; i < 20; i++) send(2047);

        finish_run();
    end
endmodule